// File: doc/BRIEF.md
# NAND Program/Erase Command Sequencer

This block turns a single host request into the byte-wide strobe traffic that an asynchronous NAND flash device expects for two write-side operations. The first is a two-plane page program: two pages are written back to back, and the first one is closed with an intermediate confirm. The second is a single block erase, which ends with a status read that reports whether the erase worked. The host supplies an operation select, a column and row address for each page, a page length, and a stream of write bytes over a valid/ready handshake. A one-cycle start pulse launches the operation. The block reports busy while it runs, and when it finishes it pulses done once with a pass flag.

All flash-side intervals are given as clock-cycle counts on input ports: the write strobe half period, the address-to-data delay, the confirm-to-ready-sample delay, the ready-to-status delay and the ready timeout. This lets one netlist serve several clock rates. Ready/busy waits are bounded by the timeout count. A two-plane request whose page addresses fall in different blocks is refused before the chip enable ever drops.

Top module: `nand_pe_seq`

## Requirements
- R1: A program (op=0) emits command 80h, then five address bytes (col_a[7:0], col_a[15:8], row_a[7:0], row_a[15:8], row_a[23:16]), then page_len data bytes, then command 11h. After ready returns, it emits 80h again with the same five-byte layout for col_b/row_b, page_len data bytes, and command 10h.
- R2: cle is high only while a command byte is on the bus and ale only while an address byte is. Each byte is taken by the flash on the rising edge of we_n, and each we_n low pulse lasts exactly t_wc cycles.
- R3: At least t_adl cycles pass between the rising we_n of the last address byte of a program phase and the falling we_n of its first data byte.
- R4: After each confirm command (11h, 10h, D0h), rb_n is not sampled until t_wb cycles have elapsed. The sequence continues only once rb_n is seen high.
- R5: A program whose row_a and row_b differ in any bit at or above PAGE_BITS other than PLANE_BIT ends with done, pass=0 and rejected=1, and ce_n never goes low. A difference in PLANE_BIT alone (bit 6 by default) is accepted.
- R6: An erase (op=1) emits command 60h, then three address bytes row_a[7:0], row_a[15:8], row_a[23:16], with no column bytes, then command D0h, and then waits for ready.
- R7: After erase ready the block waits t_whr cycles, emits command 70h, waits t_whr cycles, and drives re_n low for t_wc cycles. pass is the inverse of io_in bit 0 as sampled during that read.
- R8: io_oe is high only during command, address and data bytes, and it is low in every cycle in which re_n is low.
- R9: If rb_n stays low for more than to_limit cycles, the operation ends with done, timed_out=1 and pass=0, and no further bytes are sent.
- R10: start is ignored while busy is high. No second operation follows the running one.
- R11: done is high for exactly one cycle, with pass, rejected and timed_out valid in that cycle, and busy is low in the cycle after.
- R12: Out of reset, ce_n, we_n and re_n are high, and cle, ale, io_oe, busy and done are low.
- R13: Write bytes are consumed in order, one per wvalid and wready cycle. While wvalid is low, no data strobe is issued.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | One-cycle launch pulse |
| op | input | 1 | 0 = two-plane program, 1 = block erase |
| col_a | input | 16 | Column address of first page |
| row_a | input | 24 | Row address of first page / erased block |
| col_b | input | 16 | Column address of second page |
| row_b | input | 24 | Row address of second page |
| page_len | input | LEN_W | Data bytes per page (at least 1) |
| t_wc | input | CNT_W | Write/read strobe half period in cycles |
| t_adl | input | CNT_W | Address-to-data delay in cycles |
| t_wb | input | CNT_W | Confirm-to-ready-sample delay in cycles |
| t_whr | input | CNT_W | Ready-to-status and command-to-read delay |
| to_limit | input | CNT_W | Ready wait timeout in cycles |
| wdata | input | 8 | Write byte |
| wvalid | input | 1 | Write byte valid |
| wready | output | 1 | Write byte accepted this cycle when valid |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| pass | output | 1 | Operation succeeded (valid with done) |
| rejected | output | 1 | Plane address rule violated (valid with done) |
| timed_out | output | 1 | Ready wait exceeded limit (valid with done) |
| ce_n | output | 1 | Flash chip enable, active low |
| cle | output | 1 | Command latch enable |
| ale | output | 1 | Address latch enable |
| we_n | output | 1 | Write strobe, active low |
| re_n | output | 1 | Read strobe, active low |
| io_out | output | 8 | Byte driven to the flash bus |
| io_oe | output | 1 | Bus drive enable |
| io_in | input | 8 | Byte read from the flash bus |
| rb_n | input | 1 | Flash ready (1) / busy (0) |

## Verification
The bench builds the block with default parameters: PAGE_BITS=6 and PLANE_BIT=6, so the plane select is row bit 6 and block bits start at bit 7. Because that bit is so low, a single flipped row bit can exercise both an accepted and a refused plane pair. The interval ports are driven with small counts (t_wc=2, t_adl=7, t_wb=6, t_whr=3, to_limit=40), which keeps each operation to a few hundred cycles. The bench's ready model pulls rb_n low only four cycles after a confirm strobe. As a result, a sequencer that polls ready before t_wb sees the device still ready and runs ahead, which makes R4 observable at the pins.

// File: rtl/nand_pe_seq.sv
module nand_pe_seq #(
  parameter int CNT_W     = 16,
  parameter int LEN_W     = 12,
  parameter int PAGE_BITS = 6,
  parameter int PLANE_BIT = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             op,
  input  logic [15:0]      col_a,
  input  logic [23:0]      row_a,
  input  logic [15:0]      col_b,
  input  logic [23:0]      row_b,
  input  logic [LEN_W-1:0] page_len,
  input  logic [CNT_W-1:0] t_wc,
  input  logic [CNT_W-1:0] t_adl,
  input  logic [CNT_W-1:0] t_wb,
  input  logic [CNT_W-1:0] t_whr,
  input  logic [CNT_W-1:0] to_limit,
  input  logic [7:0]       wdata,
  input  logic             wvalid,
  output logic             wready,
  output logic             busy,
  output logic             done,
  output logic             pass,
  output logic             rejected,
  output logic             timed_out,
  output logic             ce_n,
  output logic             cle,
  output logic             ale,
  output logic             we_n,
  output logic             re_n,
  output logic [7:0]       io_out,
  output logic             io_oe,
  input  logic [7:0]       io_in,
  input  logic             rb_n
);

  localparam logic [23:0] BLK_MASK = ~((24'd1 << PAGE_BITS) - 24'd1) & ~(24'd1 << PLANE_BIT);
  localparam logic [CNT_W:0] ONE = 1;
  localparam logic [4:0] STEP_END = 5'd31;

  typedef enum logic [3:0] {
    K_CMD, K_ADDR, K_DATA, K_ADL, K_WB, K_RB, K_WHR, K_READ, K_END
  } kind_t;

  typedef enum logic [1:0] {P_LOAD, P_LO, P_HI} phase_t;

  logic             active, op_q, fail_q, rej_q, to_q;
  logic [15:0]      col_a_q, col_b_q;
  logic [23:0]      row_a_q, row_b_q;
  logic [LEN_W-1:0] plen_q, dcnt;
  logic [4:0]       step;
  phase_t           ph;
  logic [CNT_W-1:0] cnt, tgap;
  logic [7:0]       byte_q, ub;
  kind_t            kind;
  logic             xfer, wc_last, gap_last;

  always_comb begin
    kind = K_END;
    ub   = 8'h00;
    if (!op_q) begin
      case (step)
        5'd0:  begin kind = K_CMD;  ub = 8'h80; end
        5'd1:  begin kind = K_ADDR; ub = col_a_q[7:0]; end
        5'd2:  begin kind = K_ADDR; ub = col_a_q[15:8]; end
        5'd3:  begin kind = K_ADDR; ub = row_a_q[7:0]; end
        5'd4:  begin kind = K_ADDR; ub = row_a_q[15:8]; end
        5'd5:  begin kind = K_ADDR; ub = row_a_q[23:16]; end
        5'd6:  kind = K_ADL;
        5'd7:  kind = K_DATA;
        5'd8:  begin kind = K_CMD;  ub = 8'h11; end
        5'd9:  kind = K_WB;
        5'd10: kind = K_RB;
        5'd11: begin kind = K_CMD;  ub = 8'h80; end
        5'd12: begin kind = K_ADDR; ub = col_b_q[7:0]; end
        5'd13: begin kind = K_ADDR; ub = col_b_q[15:8]; end
        5'd14: begin kind = K_ADDR; ub = row_b_q[7:0]; end
        5'd15: begin kind = K_ADDR; ub = row_b_q[15:8]; end
        5'd16: begin kind = K_ADDR; ub = row_b_q[23:16]; end
        5'd17: kind = K_ADL;
        5'd18: kind = K_DATA;
        5'd19: begin kind = K_CMD;  ub = 8'h10; end
        5'd20: kind = K_WB;
        5'd21: kind = K_RB;
        default: kind = K_END;
      endcase
    end else begin
      case (step)
        5'd0: begin kind = K_CMD;  ub = 8'h60; end
        5'd1: begin kind = K_ADDR; ub = row_a_q[7:0]; end
        5'd2: begin kind = K_ADDR; ub = row_a_q[15:8]; end
        5'd3: begin kind = K_ADDR; ub = row_a_q[23:16]; end
        5'd4: begin kind = K_CMD;  ub = 8'hD0; end
        5'd5: kind = K_WB;
        5'd6: kind = K_RB;
        5'd7: kind = K_WHR;
        5'd8: begin kind = K_CMD;  ub = 8'h70; end
        5'd9: kind = K_WHR;
        5'd10: kind = K_READ;
        default: kind = K_END;
      endcase
    end
  end

  always_comb begin
    case (kind)
      K_ADL:   tgap = t_adl;
      K_WB:    tgap = t_wb;
      default: tgap = t_whr;
    endcase
  end

  assign xfer     = (kind == K_CMD) || (kind == K_ADDR) || (kind == K_DATA);
  assign wc_last  = ({1'b0, cnt} + ONE) >= {1'b0, t_wc};
  assign gap_last = ({1'b0, cnt} + ONE) >= {1'b0, tgap};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active <= 1'b0; op_q <= 1'b0; fail_q <= 1'b0; rej_q <= 1'b0; to_q <= 1'b0;
      col_a_q <= '0; col_b_q <= '0; row_a_q <= '0; row_b_q <= '0;
      plen_q <= '0; dcnt <= '0; step <= '0; ph <= P_LOAD; cnt <= '0; byte_q <= '0;
    end else if (!active) begin
      if (start) begin
        active <= 1'b1; op_q <= op;
        col_a_q <= col_a; col_b_q <= col_b; row_a_q <= row_a; row_b_q <= row_b;
        plen_q <= page_len; dcnt <= '0; ph <= P_LOAD; cnt <= '0;
        fail_q <= 1'b0; to_q <= 1'b0;
        rej_q <= !op && (((row_a ^ row_b) & BLK_MASK) != 24'd0);
        step  <= (!op && (((row_a ^ row_b) & BLK_MASK) != 24'd0)) ? STEP_END : 5'd0;
      end
    end else begin
      case (kind)
        K_CMD, K_ADDR, K_DATA: begin
          case (ph)
            P_LOAD: begin
              if (kind != K_DATA) begin
                byte_q <= ub; ph <= P_LO;
              end else if (wvalid) begin
                byte_q <= wdata; ph <= P_LO;
              end
            end
            P_LO: begin
              if (wc_last) begin cnt <= '0; ph <= P_HI; end
              else cnt <= cnt + 1'b1;
            end
            default: begin
              if (wc_last) begin
                cnt <= '0; ph <= P_LOAD;
                if (kind != K_DATA || dcnt == plen_q - 1'b1) begin
                  step <= step + 1'b1; dcnt <= '0;
                end else begin
                  dcnt <= dcnt + 1'b1;
                end
              end else cnt <= cnt + 1'b1;
            end
          endcase
        end
        K_ADL, K_WB, K_WHR: begin
          if (gap_last) begin cnt <= '0; step <= step + 1'b1; end
          else cnt <= cnt + 1'b1;
        end
        K_RB: begin
          if (rb_n) begin
            cnt <= '0; step <= step + 1'b1;
          end else if (cnt >= to_limit) begin
            cnt <= '0; to_q <= 1'b1; step <= STEP_END;
          end else cnt <= cnt + 1'b1;
        end
        K_READ: begin
          if (wc_last) begin cnt <= '0; fail_q <= io_in[0]; step <= step + 1'b1; end
          else cnt <= cnt + 1'b1;
        end
        default: active <= 1'b0;
      endcase
    end
  end

  assign busy      = active;
  assign done      = active && (kind == K_END);
  assign pass      = !(fail_q || rej_q || to_q);
  assign rejected  = rej_q;
  assign timed_out = to_q;
  assign ce_n      = !(active && kind != K_END);
  assign cle       = active && (kind == K_CMD);
  assign ale       = active && (kind == K_ADDR);
  assign we_n      = !(active && xfer && ph == P_LO);
  assign re_n      = !(active && kind == K_READ);
  assign io_oe     = active && xfer;
  assign io_out    = byte_q;
  assign wready    = active && (kind == K_DATA) && (ph == P_LOAD);

endmodule

// File: rtl/nand_pe_seq_chk.sv
module nand_pe_seq_chk (
  input logic clk,
  input logic rst_n,
  input logic start,
  input logic busy,
  input logic done,
  input logic ce_n,
  input logic cle,
  input logic ale,
  input logic we_n,
  input logic re_n,
  input logic io_oe
);

  a_r2_cle_ale_apart: assert property (@(posedge clk) disable iff (!rst_n) !(cle && ale));
  a_r2_strobe_in_ce: assert property (@(posedge clk) disable iff (!rst_n) !we_n |-> !ce_n);
  a_r8_bus_free_on_read: assert property (@(posedge clk) disable iff (!rst_n) !re_n |-> !io_oe);
  a_r8_no_dual_strobe: assert property (@(posedge clk) disable iff (!rst_n) !re_n |-> we_n);
  a_r11_done_single: assert property (@(posedge clk) disable iff (!rst_n) done |=> !done);
  a_r11_idle_after_done: assert property (@(posedge clk) disable iff (!rst_n) done |=> !busy);
  a_r10_busy_holds: assert property (@(posedge clk) disable iff (!rst_n) busy && !done |=> busy);
  a_r10_launch_by_start: assert property (@(posedge clk) disable iff (!rst_n) $rose(busy) |-> $past(start));

endmodule

bind nand_pe_seq nand_pe_seq_chk chk (
  .clk(clk), .rst_n(rst_n), .start(start), .busy(busy), .done(done), .ce_n(ce_n),
  .cle(cle), .ale(ale), .we_n(we_n), .re_n(re_n), .io_oe(io_oe)
);

// File: tb/nand_pe_seq_test.sv
module nand_pe_seq_test;
  localparam int CW = 16;
  localparam int LW = 12;
  localparam int RB_LOW_AT = 4;
  localparam int BUSY_LEN = 12;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #10 clk = ~clk;

  logic start = 0, op = 0, wvalid = 0;
  logic [15:0] col_a = 0, col_b = 0;
  logic [23:0] row_a = 0, row_b = 0;
  logic [LW-1:0] page_len = 1;
  logic [CW-1:0] t_wc = 2, t_adl = 7, t_wb = 6, t_whr = 3, to_limit = 40;
  logic [7:0] wdata = 0, io_in, status_q = 0;
  logic rb_n = 1;
  logic wready, busy, done, pass, rejected, timed_out, ce_n, cle, ale, we_n, re_n, io_oe;
  logic [7:0] io_out;

  nand_pe_seq uut (
    .clk(clk), .rst_n(rst_n), .start(start), .op(op), .col_a(col_a), .row_a(row_a),
    .col_b(col_b), .row_b(row_b), .page_len(page_len), .t_wc(t_wc), .t_adl(t_adl),
    .t_wb(t_wb), .t_whr(t_whr), .to_limit(to_limit), .wdata(wdata), .wvalid(wvalid),
    .wready(wready), .busy(busy), .done(done), .pass(pass), .rejected(rejected),
    .timed_out(timed_out), .ce_n(ce_n), .cle(cle), .ale(ale), .we_n(we_n), .re_n(re_n),
    .io_out(io_out), .io_oe(io_oe), .io_in(io_in), .rb_n(rb_n)
  );

  assign io_in = re_n ? 8'hFF : status_q;

  int tests = 0, fails = 0;
  logic [9:0] got[$];
  logic [9:0] exp_q[$];
  logic [7:0] wq[$];
  bit take = 0, stuck = 0, ce_seen = 0, conf_on = 0, after_done = 0;
  bit prev_we = 1, prev_re = 1;
  int cyc = 0, wlow = 0, relow = 0, since_addr = -1, rb_tmr = 0, done_cnt = 0;
  bit d_pass, d_rej, d_to;

  task automatic check(input bit ok, input string tag, input int act, input int expv);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, expv);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n) begin
      cyc++;
      if (take) void'(wq.pop_front());
      wvalid = (wq.size() > 0) && (cyc % 5 != 0);
      wdata  = (wq.size() > 0) ? wq[0] : 8'h00;
      take   = wvalid && wready;
      if (!ce_n) ce_seen = 1;
      if (since_addr >= 0) since_addr++;
      if (conf_on) begin
        rb_tmr++;
        rb_n = !(rb_tmr >= RB_LOW_AT && (stuck || rb_tmr < RB_LOW_AT + BUSY_LEN));
      end
      if (!we_n) wlow++;
      if (!re_n) begin
        relow++;
        check(!io_oe, "R8 bus driven while re_n low", io_oe, 0);
      end
      if (prev_re && !re_n) begin
        check(got.size() > 0 && got[got.size()-1] == 10'h270, "R7 70h precedes read",
              got.size() > 0 ? int'(got[got.size()-1]) : 0, 10'h270);
      end
      if (!prev_re && re_n) begin
        check(relow == int'(t_wc), "R7 re_n low width", relow, t_wc);
        relow = 0;
      end
      if (prev_we && !we_n) begin
        if (conf_on) begin
          check(rb_tmr >= RB_LOW_AT + BUSY_LEN, "R4 ready waited after confirm", rb_tmr, RB_LOW_AT + BUSY_LEN);
          conf_on = 0; rb_n = 1;
        end
        if (!cle && !ale && since_addr >= 0) begin
          check(since_addr >= int'(t_adl), "R3 address-to-data delay", since_addr, t_adl);
          since_addr = -1;
        end
      end
      if (!prev_we && we_n) begin
        check(wlow == int'(t_wc), "R2 we_n low width", wlow, t_wc);
        wlow = 0;
        got.push_back({cle, ale, io_out});
        if (ale) since_addr = 0;
        if (cle && (io_out == 8'h11 || io_out == 8'h10 || io_out == 8'hD0)) begin
          conf_on = 1; rb_tmr = 0;
        end
      end
      if (after_done) begin
        check(!done && !busy, "R11 done single cycle then idle", {done, busy}, 0);
        after_done = 0;
      end
      if (done) begin
        done_cnt++;
        d_pass = pass; d_rej = rejected; d_to = timed_out;
        after_done = 1;
        if (conf_on && !timed_out)
          check(rb_tmr >= RB_LOW_AT + BUSY_LEN, "R4 final ready waited", rb_tmr, RB_LOW_AT + BUSY_LEN);
        conf_on = 0; rb_n = 1;
      end
      prev_we = we_n;
      prev_re = re_n;
    end
  end

  task automatic pushx(input bit c, input bit a, input logic [7:0] b);
    exp_q.push_back({c, a, b});
  endtask

  task automatic exp_prog_half(input logic [7:0] cmd_end, input logic [15:0] c, input logic [23:0] r,
                               input int len, input int seed);
    pushx(1, 0, 8'h80);
    pushx(0, 1, c[7:0]); pushx(0, 1, c[15:8]);
    pushx(0, 1, r[7:0]); pushx(0, 1, r[15:8]); pushx(0, 1, r[23:16]);
    for (int i = 0; i < len; i++) begin
      pushx(0, 0, 8'(seed + i * 7));
      wq.push_back(8'(seed + i * 7));
    end
    pushx(1, 0, cmd_end);
  endtask

  task automatic compare(input string tag);
    check(got.size() == exp_q.size(), {tag, " byte count"}, got.size(), exp_q.size());
    for (int i = 0; i < exp_q.size() && i < got.size(); i++)
      check(got[i] == exp_q[i], {tag, " bus byte"}, got[i], exp_q[i]);
  endtask

  task automatic run(input bit o, input logic [23:0] ra, input logic [23:0] rb,
                     input logic [15:0] ca, input logic [15:0] cb, input int len, input bit poke);
    int d0;
    bit seen;
    @(negedge clk);
    op = o; row_a = ra; row_b = rb; col_a = ca; col_b = cb; page_len = LW'(len);
    got.delete(); ce_seen = 0; d0 = done_cnt; start = 1;
    @(negedge clk);
    start = 0;
    seen = 0;
    for (int i = 0; i < 5000; i++) begin
      if (poke && i == 10) begin start = 1; op = !o; end
      if (poke && i == 11) begin start = 0; op = o; end
      if (done_cnt != d0) begin seen = 1; break; end
      @(negedge clk);
    end
    check(seen, "watchdog: done never seen", seen, 1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check(ce_n && we_n && re_n && !cle && !ale && !io_oe && !busy && !done,
          "R12 reset outputs", {ce_n, we_n, re_n, cle, ale, io_oe, busy, done}, 8'hE0);
    rst_n = 1;
    repeat (2) @(negedge clk);

    // R1 R5 R13 R10: planes differ only in bit 6, stray start during run
    exp_q.delete();
    exp_prog_half(8'h11, 16'h0123, 24'h012340, 4, 8'h10);
    exp_prog_half(8'h10, 16'h0456, 24'h012300, 4, 8'h50);
    run(0, 24'h012340, 24'h012300, 16'h0123, 16'h0456, 4, 1);
    compare("R1 program sequence");
    check(d_pass && !d_rej && !d_to, "R5 plane-only difference passes", {d_pass, d_rej, d_to}, 3'b100);
    check(wq.size() == 0, "R13 all write bytes consumed", wq.size(), 0);
    ce_seen = 0;
    repeat (20) @(negedge clk);
    check(!ce_seen && !busy, "R10 stray start ignored", {ce_seen, busy}, 0);

    // R5: block bit 7 differs
    exp_q.delete(); wq.delete();
    run(0, 24'h012340, 24'h012380, 16'h0001, 16'h0002, 2, 0);
    check(!d_pass && d_rej, "R5 mismatched blocks rejected", {d_pass, d_rej}, 2'b01);
    check(!ce_seen, "R5 no bus activity on reject", ce_seen, 0);
    check(got.size() == 0, "R5 no bytes on reject", got.size(), 0);

    // R6 R7: erase success
    status_q = 8'hE0;
    exp_q.delete();
    pushx(1, 0, 8'h60); pushx(0, 1, 8'h22); pushx(0, 1, 8'h33); pushx(0, 1, 8'h04);
    pushx(1, 0, 8'hD0); pushx(1, 0, 8'h70);
    run(1, 24'h043322, 24'h0, 16'h0, 16'h0, 1, 0);
    compare("R6 erase sequence");
    check(d_pass && !d_to, "R7 status bit0 clear gives pass", d_pass, 1);

    // R7: erase failure status
    status_q = 8'hE1;
    run(1, 24'h043322, 24'h0, 16'h0, 16'h0, 1, 0);
    check(!d_pass && !d_rej && !d_to, "R7 status bit0 set gives fail", d_pass, 0);

    // R9: ready stuck low
    stuck = 1;
    exp_q.delete();
    pushx(1, 0, 8'h60); pushx(0, 1, 8'h01); pushx(0, 1, 8'h00); pushx(0, 1, 8'h00);
    pushx(1, 0, 8'hD0);
    run(1, 24'h000001, 24'h0, 16'h0, 16'h0, 1, 0);
    stuck = 0;
    check(d_to && !d_pass, "R9 timeout flagged", {d_to, d_pass}, 2'b10);
    compare("R9 no bytes after timeout");

    // R1 R3: single-byte pages
    exp_q.delete(); wq.delete();
    exp_prog_half(8'h11, 16'hBEEF, 24'hA000C0, 1, 8'hA5);
    exp_prog_half(8'h10, 16'h0010, 24'hA00080, 1, 8'h3C);
    run(0, 24'hA000C0, 24'hA00080, 16'hBEEF, 16'h0010, 1, 0);
    compare("R1 short pages");
    check(d_pass, "R1 short program passes", d_pass, 1);

    repeat (5) @(negedge clk);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    #4000000;
    fails++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule